// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block merges a set of independent event status flags into a single interrupt request. Each flag has one control bit. A build-time polarity vector fixes how each control bit works. On an enable-type flag, a control bit of 1 lets the flag through. On a mask-type flag, a control bit of 1 blocks it. The flags and control bits come from registers outside this block. Those registers, their set and clear logic, and the bus interface are not part of it.

The request pin has two output modes, chosen by a mode input:

- **Level mode (default).** The pin behaves as an open-drain, active-low line. The block drives the pin value to 0 and raises a drive-enable while any qualified flag is set.
- **Edge mode.** The pin is actively driven and carries a one-clock high pulse each time the set of qualified flags goes from empty to non-empty.

A summary output always shows whether any qualified flag is set, in either mode. While reset is held, the pin is actively driven with a test-chain value.

Top module: `irq_aggregator`

## Requirements
- R1: A flag whose POLARITY bit is 1 (enable type) contributes to the request only while its control bit is 1.
- R2: A flag whose POLARITY bit is 0 (mask type) contributes to the request only while its control bit is 0.
- R3: `irq_pending` equals the OR of all qualified flags as sampled at the previous rising clock edge. This holds in both output modes.
- R4: In level mode (`edge_mode` = 0) and out of reset, `irq_out` is 0 and `irq_oe` equals `irq_pending`.
- R5: In edge mode (`edge_mode` = 1) and out of reset, `irq_oe` is 1. `irq_out` is 1 for exactly the one cycle in which `irq_pending` has just risen, and is 0 otherwise.
- R6: In edge mode, a request that stays asserted gives only one pulse. A new pulse needs `irq_pending` to have been 0 for at least one cycle first.
- R7: While `rst_n` is 0, `irq_oe` is 1 and `irq_out` equals `test_in`, whatever the mode and the flags.
- R8: A reset edge clears the pending and edge history. If qualified flags are present at the first clock after reset, `irq_pending` rises and, in edge mode, one pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also selects test routing of the pin |
| flags | input | NUM_FLAGS | Event status flags, one per source |
| ctrl | input | NUM_FLAGS | Per-flag control bit, a mask or an enable as set by POLARITY |
| edge_mode | input | 1 | 0 = open-drain active-low level, 1 = active-high pulse |
| test_in | input | 1 | Test-chain value shown on the pin during reset |
| irq_oe | output | 1 | Pin drive enable |
| irq_out | output | 1 | Pin value when driven |
| irq_pending | output | 1 | Registered OR of qualified flags |

## Verification

**Single-flag directed cases.** Directed vectors set one flag at a time on both an enable-type position and a mask-type position, with the control bit at each value. This separates correct per-flag polarity from swapped or shared polarity.

**Edge-mode sequences.** Held, dropped and re-raised request sequences in edge mode separate a true rising-edge pulse from a level copy or a pulse that repeats.

**Random traffic.** Random flags, control bits, mode and test values cover switching between modes, and changes to the pending state in both modes.

**Reset cases.** Reset is entered and left with flags already qualified. This shows the test routing during reset and the history clearing after it.

// File: rtl/irq_agg_pkg.sv
// Package: shared types for the interrupt aggregator.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_agg_pkg;
    // Selects which source drives the request pin.
    typedef enum logic [1:0] {
        PIN_LEVEL = 2'd0,
        PIN_EDGE  = 2'd1,
        PIN_TEST  = 2'd2
    } pin_mode_e;

    // Gating rule of one flag: enable type passes on ctrl=1, mask type on ctrl=0.
    function automatic logic gate_flag(input logic flag, input logic ctl, input logic en_type);
        return flag & (en_type ? ctl : ~ctl);
    endfunction
endpackage

// File: rtl/irq_flag_qualify.sv
// Module: applies per-flag mask or enable gating.
// Assumes: POLARITY is fixed at build time; 1 = enable type, 0 = mask type.
module irq_flag_qualify #(
    parameter int unsigned            NUM_FLAGS = 17,
    parameter logic [NUM_FLAGS-1:0]   POLARITY  = '0
) (
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [NUM_FLAGS-1:0] ctrl,
    output logic [NUM_FLAGS-1:0] qual,
    output logic                 any_qual
);
    import irq_agg_pkg::*;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
            if (POLARITY[gi]) begin : g_en
                // Enable-type gate for this flag.
                always_comb qual[gi] = gate_flag(flags[gi], ctrl[gi], 1'b1);
            end else begin : g_mask
                // Mask-type gate for this flag.
                always_comb qual[gi] = gate_flag(flags[gi], ctrl[gi], 1'b0);
            end
        end
    endgenerate

    // Reduce qualified flags to one request.
    always_comb any_qual = |qual;
endmodule

// File: rtl/irq_req_track.sv
// Module: registers the request and detects its rising transition.
// Assumes: synchronous active-low reset; one-cycle latency from inputs.
module irq_req_track (
    input  logic clk,
    input  logic rst_n,
    input  logic any_qual,
    output logic pend_q,
    output logic rise_q
);
    // Hold the request level and a one-cycle rise pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            rise_q <= 1'b0;
        end else begin
            pend_q <= any_qual;
            rise_q <= any_qual & ~pend_q;
        end
    end
endmodule

// File: rtl/irq_pin_drive.sv
// Module: selects what the request pin carries.
// Assumes: reset level takes priority over the mode input.
module irq_pin_drive (
    input  logic rst_n,
    input  logic edge_mode,
    input  logic test_in,
    input  logic pend_q,
    input  logic rise_q,
    output logic irq_oe,
    output logic irq_out
);
    import irq_agg_pkg::*;

    pin_mode_e mode;

    // Decode the pin source.
    always_comb begin
        if (!rst_n)         mode = PIN_TEST;
        else if (edge_mode) mode = PIN_EDGE;
        else                mode = PIN_LEVEL;
    end

    // Drive enable and value for the chosen source.
    always_comb begin
        unique case (mode)
            PIN_TEST: begin irq_oe = 1'b1;   irq_out = test_in; end
            PIN_EDGE: begin irq_oe = 1'b1;   irq_out = rise_q;  end
            default:  begin irq_oe = pend_q; irq_out = 1'b0;    end
        endcase
    end
endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the masked interrupt request aggregator.
// Assumes: flags and ctrl are synchronous to clk.
module irq_aggregator #(
    parameter int unsigned          NUM_FLAGS = 17,
    parameter logic [NUM_FLAGS-1:0] POLARITY  = 17'h0F0A5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic [NUM_FLAGS-1:0] ctrl,
    input  logic                 edge_mode,
    input  logic                 test_in,
    output logic                 irq_oe,
    output logic                 irq_out,
    output logic                 irq_pending
);
    logic [NUM_FLAGS-1:0] qual;
    logic                 any_qual;
    logic                 pend_q;
    logic                 rise_q;

    irq_flag_qualify #(.NUM_FLAGS(NUM_FLAGS), .POLARITY(POLARITY)) u_qual (
        .flags(flags), .ctrl(ctrl), .qual(qual), .any_qual(any_qual)
    );

    irq_req_track u_track (
        .clk(clk), .rst_n(rst_n), .any_qual(any_qual),
        .pend_q(pend_q), .rise_q(rise_q)
    );

    irq_pin_drive u_pin (
        .rst_n(rst_n), .edge_mode(edge_mode), .test_in(test_in),
        .pend_q(pend_q), .rise_q(rise_q),
        .irq_oe(irq_oe), .irq_out(irq_out)
    );

    // Summary status is the registered request in every mode.
    always_comb irq_pending = pend_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
// Module: property checker bound to the aggregator top.
// Assumes: sampled at the rising clock edge.
module irq_aggregator_chk (
    input logic clk,
    input logic rst_n,
    input logic edge_mode,
    input logic test_in,
    input logic any_qual,
    input logic irq_oe,
    input logic irq_out,
    input logic irq_pending
);
    // R3
    pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_pending == $past(any_qual)));

    // R4
    level_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |-> (!irq_out && (irq_oe == irq_pending)));

    // R5
    edge_rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && $rose(irq_pending)) |-> (irq_out && irq_oe));

    // R6
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && irq_out) |=> !(edge_mode && irq_out));

    // R7
    test_route_chk: assert property (@(posedge clk)
        !rst_n |-> (irq_oe && (irq_out == test_in)));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .test_in(test_in),
    .any_qual(any_qual), .irq_oe(irq_oe), .irq_out(irq_out),
    .irq_pending(irq_pending)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
    localparam int unsigned NF  = 17;
    localparam logic [NF-1:0] POL = 17'h0F0A5; // bit0 enable type, bit1 mask type

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] flags = '0;
    logic [NF-1:0] ctrl = '0;
    logic          edge_mode = 1'b0;
    logic          test_in = 1'b0;
    logic          irq_oe, irq_out, irq_pending;

    int n_run = 0;
    int n_fail = 0;
    logic exp_pend = 1'b0;
    logic exp_rise = 1'b0;

    always #5 clk = ~clk;

    irq_aggregator #(.NUM_FLAGS(NF), .POLARITY(POL)) uut (
        .clk(clk), .rst_n(rst_n), .flags(flags), .ctrl(ctrl),
        .edge_mode(edge_mode), .test_in(test_in),
        .irq_oe(irq_oe), .irq_out(irq_out), .irq_pending(irq_pending)
    );

    function automatic logic model_any(input logic [NF-1:0] f, input logic [NF-1:0] c);
        logic r = 1'b0;
        for (int i = 0; i < NF; i++)
            r |= f[i] & (POL[i] ? c[i] : ~c[i]);
        return r;
    endfunction

    task automatic chk(input logic act, input logic exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    // Apply inputs, pass one rising edge, update the model, then compare.
    task automatic step(input logic [NF-1:0] f, input logic [NF-1:0] c,
                        input logic m, input logic t, input string tag);
        flags = f; ctrl = c; edge_mode = m; test_in = t;
        @(posedge clk);
        if (!rst_n) begin
            exp_pend = 1'b0; exp_rise = 1'b0;
        end else begin
            exp_rise = model_any(f, c) & ~exp_pend;
            exp_pend = model_any(f, c);
        end
        #2;
        chk(irq_pending, exp_pend, {tag, " R3 pending"});
        if (!rst_n) begin
            chk(irq_oe, 1'b1, {tag, " R7 oe"});
            chk(irq_out, t, {tag, " R7 out"});
        end else if (!m) begin
            chk(irq_oe, exp_pend, {tag, " R4 oe"});
            chk(irq_out, 1'b0, {tag, " R4 out"});
        end else begin
            chk(irq_oe, 1'b1, {tag, " R5 oe"});
            chk(irq_out, exp_rise, {tag, " R5 out"});
        end
    endtask

    initial begin : watchdog
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [NF-1:0] one0, one1;
        void'($urandom(32'd20240611));
        one0 = 17'd1;  // enable-type position
        one1 = 17'd2;  // mask-type position

        // R7: test routing during reset in both modes, with flags active.
        step('1, '1, 1'b0, 1'b1, "R7 rst");
        step('1, '1, 1'b1, 1'b0, "R7 rst");
        step('1, '1, 1'b1, 1'b1, "R7 rst");

        // R8: leave reset with a qualified flag present, edge mode.
        rst_n = 1'b1;
        step(one0, one0, 1'b1, 1'b0, "R8 exit");
        step(one0, one0, 1'b1, 1'b0, "R8 hold");

        // R1: enable-type flag passes only with ctrl=1.
        step(one0, '0, 1'b0, 1'b0, "R1 ctl0");
        step(one0, '0, 1'b0, 1'b0, "R1 ctl0");
        step(one0, one0, 1'b0, 1'b0, "R1 ctl1");
        step('0, '0, 1'b0, 1'b0, "R1 clr");

        // R2: mask-type flag passes only with ctrl=0.
        step(one1, one1, 1'b0, 1'b0, "R2 ctl1");
        step(one1, one1, 1'b0, 1'b0, "R2 ctl1");
        step(one1, '0, 1'b0, 1'b0, "R2 ctl0");
        step('0, '0, 1'b0, 1'b0, "R2 clr");

        // R6: held request pulses once, re-raise after a gap pulses again.
        step(one1, '0, 1'b1, 1'b0, "R6 rise");
        step(one1, '0, 1'b1, 1'b0, "R6 hold");
        step(one1 | one0, one0, 1'b1, 1'b0, "R6 hold2");
        step('0, '0, 1'b1, 1'b0, "R6 drop");
        step(one1, '0, 1'b1, 1'b0, "R6 again");
        step(one1, '0, 1'b1, 1'b0, "R6 hold3");

        // R8: reset mid-run with request held, then release.
        rst_n = 1'b0;
        step('1, '0, 1'b0, 1'b1, "R7 mid");
        rst_n = 1'b1;
        step('1, '0, 1'b1, 1'b0, "R8 re-exit");

        // Random traffic across modes; sparse flags make transitions frequent.
        for (int k = 0; k < 400; k++) begin
            logic [NF-1:0] f, c;
            f = NF'($urandom) & NF'($urandom) & NF'($urandom);
            c = NF'($urandom);
            step(f, c, 1'($urandom), 1'($urandom), "rand R1 R2");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule